// File: doc/BRIEF.md
# TDM Channel Packetizer with Context Control

This block turns the 64 kbit/s timeslots of one circuit context into packet payloads. A context is any set of channels, taken from any of the serial TDM streams, that travel together. The host marks these channels in a membership bitmap. A sample source upstream presents every timeslot of every stream, one byte per handshake. The block keeps only the member bytes. It packs a programmable number of whole TDM frames into one payload, placing one frame directly after the previous one. Each payload begins with a two-byte context descriptor, followed by a programmable number of zero padding bytes. A later stage adds the Ethernet header and the FCS.

The host edits the channel set in a shadow bitmap and then pulses a commit input. The new set takes effect only when the next packet begins. The first packet built with the new set carries an inverted switch bit in its descriptor, so the far end can tell in-band which set a packet uses. A size check flags any configuration whose payload would be empty or too large for an Ethernet frame, and such a configuration never starts a packet.

Back-pressure rules: the input side stalls (`in_ready` low) only while the block emits the descriptor and padding bytes. The output has no buffer. A byte is due in the cycle the block drives `out_valid`. If `out_ready` is low in that cycle, the byte is lost and the packet is aborted. The block then holds one error beat, with `out_eop` and `out_err` both high, until the consumer accepts it.

Top module: `tdm_pktzr`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A packet opens with two descriptor bytes. The first carries `out_sop`: bits 7:5 hold the version parameter, bit 4 holds the switch bit, and bits 3:0 are zero. The second byte is the context identifier latched from `cfg_ctx` at packet start.
- R3: `cfg_pad` (0 to 3) zero bytes follow the descriptor. `in_ready` stays low for the whole descriptor and padding phase.
- R4: Bitmap bit index = channel × stream count + stream. The payload contains, in arrival order, exactly those samples whose bit is set in the active bitmap. The source presents each frame in the order channel 0 of streams 0, 1, … and then channel 1 of streams 0, 1, ….
- R5: A packet starts at an `fs_pulse` seen while idle and spans `cfg_frames` frames, each later frame opened by its own `fs_pulse`. `out_eop` marks the highest-index member byte of the last frame, after which the block is idle. Cycles with `fs_pulse` high carry no sample.
- R6: `cfg_bad` is high when the next packet's member count is 0, when `cfg_frames` is 0, or when members × frames + 2 + `cfg_pad` exceeds 1500. While it is high, `fs_pulse` starts nothing.
- R7: Shadow bitmap writes do not change packets until `map_commit` is pulsed. The swap happens at the next packet start. That packet has its switch bit inverted against the previous packet, and later packets keep the same value.
- R8: If `out_valid` is high and `out_ready` is low, the byte is dropped. From the next cycle the block holds an error beat (data 0, `out_eop` = `out_err` = 1) until it is accepted, then becomes idle. The rest of that packet's samples are discarded.
- R9: Samples that arrive while no packet is open produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Write one shadow bitmap bit |
| map_idx | input | IW | Shadow bit index (channel × streams + stream) |
| map_val | input | 1 | Value written to the shadow bit |
| map_commit | input | 1 | Stage the shadow bitmap for the next packet start |
| cfg_frames | input | FRM_W | TDM frames per packet |
| cfg_pad | input | 2 | Zero padding bytes after the descriptor |
| cfg_ctx | input | CTX_W | Context identifier |
| cfg_bad | output | 1 | Next packet's configuration is invalid |
| fs_pulse | input | 1 | TDM frame start |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample accepted |
| in_stream | input | SW | Sample stream number |
| in_chan | input | CHW | Sample channel number |
| in_byte | input | 8 | Sample byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| out_err | output | 1 | Aborted-packet marker |

## Verification
The bench builds the block with 4 streams and 4 channels, so the 16-bit bitmap can be filled completely. Every frame can also be walked sample by sample in a few dozen cycles. With so few members, the 1500-byte limit sits between 93 and 94 frames, which puts both sides of the size check within reach. The short frames also leave room to exercise commit staging, both switch-bit transitions, and aborts during the descriptor phase and the payload phase.

// File: rtl/tdmpk_pkg.sv
package tdmpk_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY, ST_ABT} seq_st_t;
  localparam int DESC_BYTES = 2;
  localparam int MAX_BODY   = 1500;
endpackage

// File: rtl/tdmpk_map.sv
module tdmpk_map #(
  parameter  int MW = 1024,
  localparam int IW = $clog2(MW),
  localparam int CW = $clog2(MW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          map_we,
  input  logic [IW-1:0] map_idx,
  input  logic          map_val,
  input  logic          commit,
  input  logic          take,
  output logic [MW-1:0] act_map,
  output logic [CW-1:0] nxt_members,
  output logic [IW-1:0] last_idx,
  output logic          sw_bit
);
  logic [MW-1:0] shadow;
  logic [MW-1:0] nxt_map;
  logic          pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow  <= '0;
      act_map <= '0;
      pend    <= 1'b0;
      sw_bit  <= 1'b0;
    end else begin
      if (map_we) shadow[map_idx] <= map_val;
      if (take && pend) begin
        act_map <= shadow;
        sw_bit  <= ~sw_bit;
        pend    <= 1'b0;
      end
      if (commit) pend <= 1'b1;
    end
  end

  assign nxt_map = pend ? shadow : act_map;

  always_comb begin
    nxt_members = '0;
    for (int i = 0; i < MW; i++) nxt_members = nxt_members + CW'(nxt_map[i]);
  end

  always_comb begin
    last_idx = '0;
    for (int i = 0; i < MW; i++) if (act_map[i]) last_idx = IW'(i);
  end
endmodule

// File: rtl/tdmpk_size.sv
module tdmpk_size #(
  parameter  int CW    = 11,
  parameter  int FRM_W = 8,
  localparam int BW    = CW + FRM_W + 2
) (
  input  logic [CW-1:0]    members,
  input  logic [FRM_W-1:0] frames,
  input  logic [1:0]       pad,
  output logic             bad
);
  import tdmpk_pkg::*;
  logic [BW-1:0] body;

  assign body = BW'(members) * BW'(frames) + BW'(DESC_BYTES) + BW'(pad);
  assign bad  = (members == '0) || (frames == '0) || (body > BW'(MAX_BODY));
endmodule

// File: rtl/tdmpk_seq.sv
module tdmpk_seq #(
  parameter  int         NSTREAM = 32,
  parameter  int         NCHAN   = 32,
  parameter  int         CTX_W   = 8,
  parameter  int         FRM_W   = 8,
  parameter  logic [2:0] VER     = 3'd1,
  localparam int         MW      = NSTREAM * NCHAN,
  localparam int         IW      = $clog2(MW),
  localparam int         SW      = $clog2(NSTREAM),
  localparam int         CHW     = $clog2(NCHAN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_pulse,
  input  logic             cfg_bad,
  input  logic [FRM_W-1:0] cfg_frames,
  input  logic [1:0]       cfg_pad,
  input  logic [CTX_W-1:0] cfg_ctx,
  input  logic             sw_bit,
  input  logic [MW-1:0]    act_map,
  input  logic [IW-1:0]    last_idx,
  output logic             take,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SW-1:0]    in_stream,
  input  logic [CHW-1:0]   in_chan,
  input  logic [7:0]       in_byte,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             out_err
);
  import tdmpk_pkg::*;

  seq_st_t          state;
  logic [2:0]       hcnt;
  logic [2:0]       hdr_len;
  logic [FRM_W-1:0] frm, lfrm;
  logic [1:0]       lpad;
  logic [CTX_W-1:0] lctx;
  logic [IW-1:0]    idx;
  logic             is_mem, hit, last;

  assign idx     = IW'(in_chan) * IW'(NSTREAM) + IW'(in_stream);
  assign is_mem  = ({1'b0, idx} < (IW + 1)'(MW)) && act_map[idx];
  assign hit     = (state == ST_PAY) && in_valid && is_mem;
  assign last    = (frm == lfrm - FRM_W'(1)) && (idx == last_idx);
  assign take    = (state == ST_IDLE) && fs_pulse && !cfg_bad;
  assign hdr_len = 3'(DESC_BYTES) + {1'b0, lpad};

  always_comb begin
    in_ready  = 1'b1;
    out_valid = 1'b0;
    out_data  = 8'h00;
    out_sop   = 1'b0;
    out_eop   = 1'b0;
    out_err   = 1'b0;
    case (state)
      ST_HDR: begin
        in_ready  = 1'b0;
        out_valid = 1'b1;
        out_sop   = (hcnt == 3'd0);
        if (hcnt == 3'd0)      out_data = {VER, sw_bit, 4'b0000};
        else if (hcnt == 3'd1) out_data = 8'(lctx);
      end
      ST_PAY: begin
        out_valid = hit;
        out_data  = in_byte;
        out_eop   = hit && last;
      end
      ST_ABT: begin
        out_valid = 1'b1;
        out_eop   = 1'b1;
        out_err   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      hcnt  <= '0;
      frm   <= '0;
      lfrm  <= '0;
      lpad  <= '0;
      lctx  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (take) begin
          state <= ST_HDR;
          hcnt  <= '0;
          frm   <= '0;
          lfrm  <= cfg_frames;
          lpad  <= cfg_pad;
          lctx  <= cfg_ctx;
        end
        ST_HDR: begin
          if (!out_ready)                 state <= ST_ABT;
          else if (hcnt == hdr_len - 3'd1) state <= ST_PAY;
          else                            hcnt  <= hcnt + 3'd1;
        end
        ST_PAY: begin
          if (fs_pulse) frm <= frm + FRM_W'(1);
          if (hit) begin
            if (!out_ready) state <= ST_ABT;
            else if (last)  state <= ST_IDLE;
          end
        end
        ST_ABT: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tdm_pktzr.sv
module tdm_pktzr #(
  parameter  int         NSTREAM = 32,
  parameter  int         NCHAN   = 32,
  parameter  int         CTX_W   = 8,
  parameter  int         FRM_W   = 8,
  parameter  logic [2:0] VER     = 3'd1,
  localparam int         MW      = NSTREAM * NCHAN,
  localparam int         IW      = $clog2(MW),
  localparam int         CW      = $clog2(MW + 1),
  localparam int         SW      = $clog2(NSTREAM),
  localparam int         CHW     = $clog2(NCHAN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             map_we,
  input  logic [IW-1:0]    map_idx,
  input  logic             map_val,
  input  logic             map_commit,
  input  logic [FRM_W-1:0] cfg_frames,
  input  logic [1:0]       cfg_pad,
  input  logic [CTX_W-1:0] cfg_ctx,
  output logic             cfg_bad,
  input  logic             fs_pulse,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SW-1:0]    in_stream,
  input  logic [CHW-1:0]   in_chan,
  input  logic [7:0]       in_byte,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             out_err
);
  logic [MW-1:0] act_map;
  logic [CW-1:0] nxt_members;
  logic [IW-1:0] last_idx;
  logic          sw_bit;
  logic          pkt_take;

  tdmpk_map #(.MW(MW)) u_map (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_idx(map_idx),
    .map_val(map_val), .commit(map_commit), .take(pkt_take),
    .act_map(act_map), .nxt_members(nxt_members), .last_idx(last_idx),
    .sw_bit(sw_bit)
  );

  tdmpk_size #(.CW(CW), .FRM_W(FRM_W)) u_size (
    .members(nxt_members), .frames(cfg_frames), .pad(cfg_pad), .bad(cfg_bad)
  );

  tdmpk_seq #(.NSTREAM(NSTREAM), .NCHAN(NCHAN), .CTX_W(CTX_W),
              .FRM_W(FRM_W), .VER(VER)) u_seq (
    .clk(clk), .rst_n(rst_n), .fs_pulse(fs_pulse), .cfg_bad(cfg_bad),
    .cfg_frames(cfg_frames), .cfg_pad(cfg_pad), .cfg_ctx(cfg_ctx),
    .sw_bit(sw_bit), .act_map(act_map), .last_idx(last_idx), .take(pkt_take),
    .in_valid(in_valid), .in_ready(in_ready), .in_stream(in_stream),
    .in_chan(in_chan), .in_byte(in_byte), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_err(out_err)
  );
endmodule

// File: rtl/tdm_pktzr_chk.sv
module tdm_pktzr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_bad,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sop,
  input logic       out_eop,
  input logic       out_err
);
  // R2
  sop_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid);
  // R3
  hdr_stalls_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> !in_ready);
  // R6
  bad_cfg_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && cfg_bad) |=> !out_sop);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !out_err) |=> (out_valid && out_err && out_eop));
  // R8
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err && !out_ready) |=> (out_valid && out_err && $stable(out_data)));
  // R8
  err_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_eop && out_valid));
endmodule

bind tdm_pktzr tdm_pktzr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_bad(cfg_bad), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err)
);

// File: tb/sim_tdm_pktzr.sv
module sim_tdm_pktzr;
  localparam int NS = 4;
  localparam int NC = 4;
  localparam int MW = NS * NC;
  localparam logic [2:0] VER = 3'd5;

  typedef struct {
    logic [7:0] d;
    logic sop, eop, err;
    string rq;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic map_we = 0, map_val = 0, map_commit = 0;
  logic [3:0] map_idx = '0;
  logic [7:0] cfg_frames = 8'd1;
  logic [1:0] cfg_pad = '0;
  logic [7:0] cfg_ctx = '0;
  logic cfg_bad;
  logic fs_pulse = 0, in_valid = 0, in_ready;
  logic [1:0] in_stream = '0, in_chan = '0;
  logic [7:0] in_byte = '0;
  logic out_valid, out_ready = 1, out_sop, out_eop, out_err;
  logic [7:0] out_data;

  int total = 0, bad = 0;
  exp_t q[$];
  logic [MW-1:0] m_shadow = '0, m_active = '0;
  bit m_pend = 0, m_sw = 0;

  always #4 clk = ~clk;

  tdm_pktzr #(.NSTREAM(NS), .NCHAN(NC), .CTX_W(8), .FRM_W(8), .VER(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_idx(map_idx),
    .map_val(map_val), .map_commit(map_commit), .cfg_frames(cfg_frames),
    .cfg_pad(cfg_pad), .cfg_ctx(cfg_ctx), .cfg_bad(cfg_bad),
    .fs_pulse(fs_pulse), .in_valid(in_valid), .in_ready(in_ready),
    .in_stream(in_stream), .in_chan(in_chan), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk(0, "R9 unexpected beat", int'(out_data), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({out_data, out_sop, out_eop, out_err} == {e.d, e.sop, e.eop, e.err},
            e.rq, int'({out_data, out_sop, out_eop, out_err}),
            int'({e.d, e.sop, e.eop, e.err}));
      end
    end
  end

  task automatic push(input logic [7:0] d, input bit s, input bit e, input bit r, input string rq);
    exp_t x;
    x.d = d; x.sop = s; x.eop = e; x.err = r; x.rq = rq;
    q.push_back(x);
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic write_map(input logic [MW-1:0] m);
    for (int i = 0; i < MW; i++) begin
      map_we = 1; map_idx = 4'(i); map_val = m[i];
      cyc();
    end
    map_we = 0;
    m_shadow = m;
  endtask

  task automatic commit();
    map_commit = 1; cyc(); map_commit = 0;
    m_pend = 1;
  endtask

  task automatic strobe();
    fs_pulse = 1; cyc(); fs_pulse = 0;
  endtask

  task automatic send(input int ch, input int st, input logic [7:0] b);
    in_valid = 1; in_chan = 2'(ch); in_stream = 2'(st); in_byte = b;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    cyc();
    in_valid = 0;
  endtask

  function automatic bit exp_bad(input logic [MW-1:0] m, input int fr, input int pad);
    int n = $countones(m);
    return (n == 0) || (fr == 0) || (n * fr + 2 + pad > 1500);
  endfunction

  function automatic logic [7:0] smp(input int seed, input int f, input int idx);
    return 8'(seed ^ (f << 4) ^ (idx * 7));
  endfunction

  task automatic run_pkt(input int nfr, input int pad, input int ctx, input int seed);
    int last = 0;
    cfg_frames = 8'(nfr); cfg_pad = 2'(pad); cfg_ctx = 8'(ctx);
    #1;
    // R6
    chk(cfg_bad == 0, "R6 cfg valid", int'(cfg_bad), 0);
    if (m_pend) begin m_active = m_shadow; m_sw = ~m_sw; m_pend = 0; end
    for (int i = 0; i < MW; i++) if (m_active[i]) last = i;
    // R2 R7 descriptor, R3 padding
    push({VER, m_sw, 4'b0}, 1, 0, 0, "R2/R7 descriptor byte0");
    push(8'(ctx), 0, 0, 0, "R2 ctx byte");
    for (int p = 0; p < pad; p++) push(8'h00, 0, 0, 0, "R3 pad byte");
    for (int f = 0; f < nfr; f++) begin
      strobe();
      if (f == 0) begin
        @(negedge clk);
        chk(in_ready == 0, "R3 input stalled in header", int'(in_ready), 0);
        cyc();
      end
      for (int ch = 0; ch < NC; ch++)
        for (int st = 0; st < NS; st++) begin
          int idx = ch * NS + st;
          logic [7:0] b = smp(seed, f, idx);
          // R4 member filtering and order, R5 eop on last frame
          if (m_active[idx]) push(b, 0, (f == nfr - 1) && (idx == last), 0, "R4/R5 payload");
          send(ch, st, b);
        end
    end
    repeat (2) cyc();
  endtask

  task automatic idle_samples();
    for (int i = 0; i < 4; i++) send(i, 3 - i, 8'hEE);
  endtask

  initial begin
    repeat (3) cyc();
    // R1 reset state
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1, "R1 in_ready in reset", int'(in_ready), 1);
    cyc();
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && in_ready == 1, "R1 after reset", int'({out_valid, in_ready}), 1);
    // R6 empty map flagged bad
    chk(cfg_bad == 1, "R6 empty map", int'(cfg_bad), 1);
    cyc();
    // R9 samples while idle, and R6 strobe with bad config
    strobe();
    idle_samples();
    write_map(16'b0000_1000_0110_0001);
    commit();
    // R9 no output before a packet opens
    idle_samples();
    run_pkt(2, 1, 8'h3C, 8'h11);
    // R7 no commit: switch bit stays
    run_pkt(3, 0, 8'h42, 8'h22);
    // R7 shadow write without commit has no effect
    write_map(16'hFFFF);
    run_pkt(1, 2, 8'h07, 8'h33);
    commit();
    run_pkt(2, 3, 8'h99, 8'h44);
    // R6 size limits with 16 members: 93 frames fit, 94 do not
    cfg_pad = 0; cfg_frames = 8'd93; #1;
    chk(cfg_bad == exp_bad(16'hFFFF, 93, 0), "R6 93 frames", int'(cfg_bad), 0);
    cfg_frames = 8'd94; #1;
    chk(cfg_bad == exp_bad(16'hFFFF, 94, 0), "R6 94 frames", int'(cfg_bad), 1);
    cfg_frames = 8'd0; #1;
    chk(cfg_bad == 1, "R6 zero frames", int'(cfg_bad), 1);
    // R6 strobe while bad starts nothing
    strobe();
    idle_samples();
    // R8 abort during payload
    cfg_frames = 8'd2; cfg_pad = 0; cfg_ctx = 8'h55; cyc();
    push({VER, m_sw, 4'b0}, 1, 0, 0, "R8 pre-abort desc");
    push(8'h55, 0, 0, 0, "R8 pre-abort ctx");
    push(8'h00, 0, 1, 1, "R8 payload abort beat");
    strobe();
    out_ready = 0;
    out_ready = 1;
    repeat (2) cyc();
    out_ready = 0;
    send(0, 0, 8'hA5);
    cyc();
    out_ready = 1;
    for (int st = 1; st < NS; st++) send(0, st, 8'h5A);
    repeat (2) cyc();
    // R8 abort during header
    push(8'h00, 0, 1, 1, "R8 header abort beat");
    strobe();
    out_ready = 0;
    repeat (2) cyc();
    out_ready = 1;
    repeat (3) cyc();
    // R8 recovery: normal packet afterwards
    run_pkt(1, 2, 8'h0F, 8'h66);
    repeat (4) cyc();
    chk(q.size() == 0, "R5 all expected bytes seen", q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule